// File: doc/BRIEF.md
# Two-Read One-Write Register File

This block stores the eight 32-bit working registers of a small processor datapath. Two read ports each take a 4-bit register number and return the selected word. The result appears combinationally in the same cycle, with no clock involved, so a decode stage can fetch both operands at once. One write port takes a register number and a data word, and it commits the word to storage on the rising clock edge.

Register numbers 0 through 7 select a real register. The number 8 is the "no register" code: a port that carries it performs no access. The same holds for every value from 9 to 15. A read port given such a number returns zero, and a write port given such a number changes nothing. A synchronous, active-high reset clears every register.

All three ports are plain level-driven pins. They carry no handshake, so a read is never stalled and a write is never refused. The caller presents an address, and the block either answers in the same cycle or commits at the next edge.

Top module: `regfile_2r1w`

## Requirements
- R1: When `rst` is 1 at a rising edge of `clk`, all eight registers read as 0 after that edge.
- R2: When `rd_a_id` is in 0..7, `rd_a_data` equals the current contents of that register in the same cycle, with no clock edge needed.
- R3: When `rd_b_id` is in 0..7, `rd_b_data` equals the current contents of that register in the same cycle, independently of port A.
- R4: At a rising edge with `rst` 0 and `wr_id` in 0..7, register `wr_id` takes `wr_data`, and every other register keeps its value.
- R5: At a rising edge with `wr_id` of 8 or more (8 is the no-access code), no register changes.
- R6: A read port whose register number is 8 or more outputs 0.
- R7: When a read port and the write port name the same register in one cycle, the read returns the old contents until the edge and the new contents after it.
- R8: When `rst` and a valid write fall on the same edge, reset wins and the target register reads 0.
- R9: Both read ports may select the same register in one cycle, and they then return identical words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous active-high clear of all registers |
| rd_a_id | input | 4 | Register number for read port A |
| rd_a_data | output | 32 | Word read on port A |
| rd_b_id | input | 4 | Register number for read port B |
| rd_b_data | output | 32 | Word read on port B |
| wr_id | input | 4 | Register number for the write port |
| wr_data | input | 32 | Word to write |

## Verification
Within one cycle, a read of register N can meet a write to register N. The bench steers a read port onto the register that the write port targets, often during random stimulus and also in directed steps. It samples the read output once between the edges, where it must show the old word, and again after the edge, where it must show the new word. A second clash pairs reset with a write on the same edge, and afterwards the target register must read zero.

// File: rtl/rf_pkg.sv
package rf_pkg;
  // Default geometry of the register file
  localparam int RF_NREG   = 8;
  localparam int RF_DATA_W = 32;
  localparam int RF_ID_W   = 4;
endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
  parameter int NREG = rf_pkg::RF_NREG,
  parameter int ID_W = rf_pkg::RF_ID_W
) (
  input  logic [ID_W-1:0] wr_id,
  output logic [NREG-1:0] wr_en
);
  // One-hot enable; numbers at or above NREG select nothing
  always_comb begin
    wr_en = '0;
    for (int i = 0; i < NREG; i++) begin
      if (wr_id == ID_W'(i)) wr_en[i] = 1'b1;
    end
  end
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int NREG   = rf_pkg::RF_NREG,
  parameter int DATA_W = rf_pkg::RF_DATA_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NREG-1:0]              wr_en,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [NREG-1:0][DATA_W-1:0]  regs
);
  for (genvar g = 0; g < NREG; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)            regs[g] <= '0;
      else if (wr_en[g])  regs[g] <= wr_data;
    end
  end

  // R1 / R8: a reset edge leaves every word cleared, whatever the write enable
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (regs == '0));

  // R4 / R5: with no enable raised, storage holds
  p_hold_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en == '0) |=> $stable(regs));
endmodule

// File: rtl/rf_rd_port.sv
module rf_rd_port #(
  parameter int NREG   = rf_pkg::RF_NREG,
  parameter int DATA_W = rf_pkg::RF_DATA_W,
  parameter int ID_W   = rf_pkg::RF_ID_W
) (
  input  logic [ID_W-1:0]              rd_id,
  input  logic [NREG-1:0][DATA_W-1:0]  regs,
  output logic [DATA_W-1:0]            rd_data
);
  // Combinational select; an unmatched number yields zero
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_id == ID_W'(i)) rd_data = regs[i];
    end
  end
endmodule

// File: rtl/regfile_2r1w.sv
module regfile_2r1w #(
  parameter int NREG   = rf_pkg::RF_NREG,
  parameter int DATA_W = rf_pkg::RF_DATA_W,
  parameter int ID_W   = rf_pkg::RF_ID_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ID_W-1:0]   rd_a_id,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [ID_W-1:0]   rd_b_id,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic [ID_W-1:0]   wr_id,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int              NPORT   = 2;
  localparam int              IDX_W   = $clog2(NREG);
  localparam logic [ID_W-1:0] NREG_ID = ID_W'(NREG);

  logic [NREG-1:0]              wr_en;
  logic [NREG-1:0][DATA_W-1:0]  regs_w;
  logic [NPORT-1:0][ID_W-1:0]   rd_ids;
  logic [NPORT-1:0][DATA_W-1:0] rd_words;

  assign rd_ids    = {rd_b_id, rd_a_id};
  assign rd_a_data = rd_words[0];
  assign rd_b_data = rd_words[1];

  rf_wr_decode #(.NREG(NREG), .ID_W(ID_W)) u_dec (
    .wr_id (wr_id),
    .wr_en (wr_en)
  );

  rf_storage #(.NREG(NREG), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .regs    (regs_w)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    rf_rd_port #(.NREG(NREG), .DATA_W(DATA_W), .ID_W(ID_W)) u_rd (
      .rd_id   (rd_ids[p]),
      .regs    (regs_w),
      .rd_data (rd_words[p])
    );
  end

  // R4: a valid write lands in the addressed word at the edge
  p_write_lands_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_id < NREG_ID) |=> (regs_w[$past(wr_id[IDX_W-1:0])] == $past(wr_data)));

  // R5: the no-access code leaves storage untouched
  p_reserved_noop_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_id >= NREG_ID) |=> $stable(regs_w));

  // R6: out-of-range reads yield zero on both ports
  p_oob_zero_r6: assert property (@(posedge clk) disable iff (rst)
    ((rd_a_id >= NREG_ID) |-> (rd_a_data == '0)) and
    ((rd_b_id >= NREG_ID) |-> (rd_b_data == '0)));

  // R9: ports naming the same register agree
  p_ports_agree_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_a_id == rd_b_id) |-> (rd_a_data == rd_b_data));

  // R2: port A reflects storage for a valid number
  p_read_a_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_a_id < NREG_ID) |-> (rd_a_data == regs_w[rd_a_id[IDX_W-1:0]]));
endmodule

// File: tb/test_regfile_2r1w.sv
module test_regfile_2r1w;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  rd_a_id = '0, rd_b_id = '0, wr_id = 4'd8;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_a_data, rd_b_data;

  logic [31:0] model [8];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regfile_2r1w i_regfile_2r1w (
    .clk(clk), .rst(rst),
    .rd_a_id(rd_a_id), .rd_a_data(rd_a_data),
    .rd_b_id(rd_b_id), .rd_b_data(rd_b_data),
    .wr_id(wr_id), .wr_data(wr_data)
  );

  function automatic logic [31:0] exp_read(input logic [3:0] id);
    if (id >= 4'd8) return 32'h0;
    return model[id[2:0]];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Model update at an edge, from the inputs present before it
  task automatic edge_step();
    logic       r  = rst;
    logic [3:0] id = wr_id;
    logic [31:0] d = wr_data;
    @(posedge clk);
    if (r) begin
      for (int i = 0; i < 8; i++) model[i] = '0;
    end else if (id < 4'd8) model[id[2:0]] = d;
  endtask

  task automatic drive(input logic r, input logic [3:0] ra, input logic [3:0] rb,
                       input logic [3:0] wi, input logic [31:0] wd);
    @(negedge clk);
    rst = r; rd_a_id = ra; rd_b_id = rb; wr_id = wi; wr_data = wd;
    #1;
  endtask

  task automatic check_reads(input string ra, input string rb);
    check(ra, rd_a_data, exp_read(rd_a_id));
    check(rb, rd_b_data, exp_read(rd_b_id));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7301));
    for (int i = 0; i < 8; i++) model[i] = 32'hDEAD_0000 + i;
    // R1: reset clears every register
    drive(1, 0, 1, 4'd8, 0); edge_step();
    for (int i = 0; i < 8; i++) begin
      drive(0, 4'(i), 4'(7 - i), 4'd8, 0);
      check("R1", rd_a_data, 32'h0);
      edge_step();
    end
    // R4: fill each register, R2/R3 read back
    for (int i = 0; i < 8; i++) begin
      drive(0, 0, 0, 4'(i), 32'hA5A5_0000 | (i * 32'h1111)); edge_step();
    end
    for (int i = 0; i < 8; i++) begin
      drive(0, 4'(i), 4'(i ^ 3), 4'd8, 0);
      check_reads("R2", "R3");
      check("R4", rd_a_data, 32'hA5A5_0000 | (i * 32'h1111));
      edge_step();
    end
    // R5: no-access write codes change nothing
    for (int c = 8; c < 16; c++) begin
      drive(0, 4'(c - 8), 4'(c), 4'(c), 32'hFFFF_FFFF); edge_step();
      drive(0, 4'(c - 8), 4'(c), 4'd8, 0);
      check("R5", rd_a_data, exp_read(4'(c - 8)));
      check("R6", rd_b_data, 32'h0);
      edge_step();
    end
    // R7: read-during-write on the same register
    drive(0, 4'd3, 4'd3, 4'd3, 32'h1234_5678);
    check("R7 before edge", rd_a_data, 32'hA5A5_3333);
    check("R9", rd_b_data, rd_a_data);
    edge_step();
    drive(0, 4'd3, 4'd5, 4'd8, 0);
    check("R7 after edge", rd_a_data, 32'h1234_5678);
    edge_step();
    // R8: reset beats a simultaneous write
    drive(1, 4'd2, 4'd2, 4'd2, 32'hCAFE_F00D); edge_step();
    drive(0, 4'd2, 4'd6, 4'd8, 0);
    check("R8", rd_a_data, 32'h0);
    check("R1", rd_b_data, 32'h0);
    edge_step();
    // Random mix with frequent same-register collisions
    for (int n = 0; n < 600; n++) begin
      logic [3:0] wi = 4'($urandom_range(0, 11));
      logic [3:0] ra = ($urandom_range(0, 3) == 0) ? wi : 4'($urandom_range(0, 15));
      logic [3:0] rb = ($urandom_range(0, 4) == 0) ? ra : 4'($urandom_range(0, 15));
      logic       r  = ($urandom_range(0, 63) == 0);
      drive(r, ra, rb, wi, $urandom);
      check_reads("R2/R7 random", "R3/R9 random");
      edge_step();
    end
    drive(0, 4'd0, 4'd15, 4'd8, 0);
    check_reads("R2 final", "R6 final");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule